// File: doc/BRIEF.md
# UART channel mode router

This block sits between a UART's serial receiver and transmitter, its receive and transmit FIFOs and the processor's data register. A two-bit channel mode decides where bytes go. In normal operation received bytes go to the receive FIFO and processor writes go to the transmit FIFO. In echo operation each received byte also goes back out through the transmit FIFO. In local loopback, processor writes come straight back into the receive FIFO. In remote loopback, received bytes are sent back out without the processor seeing them.

A small control register gates the receive and transmit paths. Each path has its own enable bit and its own disable bit, and disable wins. The same register carries two self-clearing FIFO reset bits. The block counts no data itself. It reads the FIFOs' full flags and fill counts, and it drives push, pop and flush strobes, overflow pulses, and a count of how many more bytes the receiver may deliver.

Top module: `uart_chan_router`

## Requirements
- R1: After reset the control register reads 0x128: bit 3 (receive disable), bit 5 (transmit disable) and bit 8 are set. With these values no received byte and no processor write causes any FIFO push.
- R2: The receive path is open only while control bit 2 is 1 and bit 3 is 0. The transmit path is open only while bit 4 is 1 and bit 5 is 0. A control write takes effect in the cycle after the write cycle.
- R3: Writing 1 to control bit 0 (receive FIFO reset) or bit 1 (transmit FIFO reset) raises the matching flush output for exactly the one cycle after the write. Both bits always read back as 0.
- R4: In mode 0 (normal), a received byte is pushed into the receive FIFO in the same cycle, with its data unchanged. A processor data write is pushed into the transmit FIFO in the same cycle.
- R5: In mode 1 (echo), a received byte is pushed into both FIFOs in the same cycle. Processor data writes cause no push.
- R6: In mode 2 (local loopback), a processor data write is pushed into the receive FIFO. Received bytes cause no push.
- R7: In mode 3 (remote loopback), a received byte is pushed into the transmit FIFO only. Processor data writes cause no push.
- R8: A byte routed to an open path whose FIFO reports full is dropped with no push. It raises that path's overflow pulse (receive or transmit) in the same cycle.
- R9: A received break is delivered as the byte 0x00 and follows the same routing as a received byte.
- R10: A processor read while the receive path is open and the receive count is non-zero pops the receive FIFO in the same cycle and returns the FIFO head. Any other read returns 0 and does not pop.
- R11: The receive allowance equals the receive FIFO's free space in normal mode and the transmit FIFO's free space in remote loopback. In echo mode it is the smaller of the two. In local loopback it is the larger FIFO depth. The ready output is high exactly when the allowance is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 9 | Control register write data |
| ctrl_o | output | 9 | Current control register value |
| rx_valid_i | input | 1 | Received byte strobe from the serial receiver |
| rx_break_i | input | 1 | Received break strobe |
| rx_data_i | input | 8 | Received byte |
| cpu_wr_i | input | 1 | Processor data register write |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_rd_i | input | 1 | Processor data register read |
| cpu_rdata_o | output | 8 | Processor read data |
| rxf_full_i | input | 1 | Receive FIFO full |
| rxf_count_i | input | 7 | Receive FIFO fill count |
| rxf_rdata_i | input | 8 | Receive FIFO head byte |
| txf_full_i | input | 1 | Transmit FIFO full |
| txf_count_i | input | 7 | Transmit FIFO fill count |
| rxf_push_o | output | 1 | Receive FIFO push |
| rxf_wdata_o | output | 8 | Receive FIFO push data |
| rxf_pop_o | output | 1 | Receive FIFO pop |
| rxf_flush_o | output | 1 | Receive FIFO flush |
| txf_push_o | output | 1 | Transmit FIFO push |
| txf_wdata_o | output | 8 | Transmit FIFO push data |
| txf_flush_o | output | 1 | Transmit FIFO flush |
| rx_ovr_o | output | 1 | Receive overflow pulse |
| tx_ovr_o | output | 1 | Transmit overflow pulse |
| rx_space_o | output | 7 | Receive allowance in bytes |
| rx_ready_o | output | 1 | Receiver may deliver a byte |

## Verification
Routing, overflow, read and allowance results come from logic with no register on the way. They are due in the same cycle as the stimulus, and the bench samples them one nanosecond after it drives its inputs on the falling edge. Control writes and flush pulses pass through one register. Their effects are checked at the falling edge after the rising edge that captured the write, and the flush is checked again one cycle later to confirm the pulse has ended.

// File: rtl/uart_router_pkg.sv
package uart_router_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_ECHO   = 2'd1,
    MODE_LOCAL  = 2'd2,
    MODE_REMOTE = 2'd3
  } chan_mode_e;

  localparam int unsigned CTRL_W      = 9;
  localparam int unsigned BIT_RX_RST  = 0;
  localparam int unsigned BIT_TX_RST  = 1;
  localparam int unsigned BIT_RX_EN   = 2;
  localparam int unsigned BIT_RX_DIS  = 3;
  localparam int unsigned BIT_TX_EN   = 4;
  localparam int unsigned BIT_TX_DIS  = 5;
  localparam logic [CTRL_W-1:0] CTRL_RST_VAL = 9'h128;
endpackage

// File: rtl/uart_router_ctrl.sv
module uart_router_ctrl
  import uart_router_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              rx_flush_o,
  output logic              tx_flush_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              rx_flush_q, tx_flush_q;

  // reset bits act once and never stick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= CTRL_RST_VAL;
      rx_flush_q <= 1'b0;
      tx_flush_q <= 1'b0;
    end else begin
      rx_flush_q <= we_i & wdata_i[BIT_RX_RST];
      tx_flush_q <= we_i & wdata_i[BIT_TX_RST];
      if (we_i) begin
        ctrl_q <= wdata_i;
        ctrl_q[BIT_RX_RST] <= 1'b0;
        ctrl_q[BIT_TX_RST] <= 1'b0;
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign rx_en_o    = ctrl_q[BIT_RX_EN] & ~ctrl_q[BIT_RX_DIS];
  assign tx_en_o    = ctrl_q[BIT_TX_EN] & ~ctrl_q[BIT_TX_DIS];
  assign rx_flush_o = rx_flush_q;
  assign tx_flush_o = tx_flush_q;

  // R3
  rx_flush_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wdata_i[BIT_RX_RST] |=> rx_flush_o);
  // R3
  tx_flush_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_o |-> $past(we_i && wdata_i[BIT_TX_RST]));
  // R2
  rx_dis_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wdata_i[BIT_RX_DIS] |=> !rx_en_o);
endmodule

// File: rtl/uart_router_gate.sv
module uart_router_gate #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [DW-1:0] data_i,
  input  logic          en_i,
  input  logic          full_i,
  output logic          push_o,
  output logic [DW-1:0] wdata_o,
  output logic          ovr_o
);
  logic pass;
  assign pass    = req_i & en_i;
  assign push_o  = pass & ~full_i;
  assign ovr_o   = pass & full_i;
  assign wdata_o = data_i;

  // R8
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_i |-> !push_o);
  // R8
  ovr_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> req_i && !push_o);
endmodule

// File: rtl/uart_router_space.sv
module uart_router_space
  import uart_router_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 64,
  parameter int unsigned TX_DEPTH = 64,
  localparam int unsigned MAX_D   = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
  localparam int unsigned CW      = $clog2(MAX_D + 1)
) (
  input  chan_mode_e    mode_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic [CW-1:0] tx_count_i,
  output logic [CW-1:0] space_o,
  output logic          ready_o
);
  localparam logic [CW-1:0] RX_D = CW'(RX_DEPTH);
  localparam logic [CW-1:0] TX_D = CW'(TX_DEPTH);
  localparam logic [CW-1:0] MX_D = CW'(MAX_D);

  logic [CW-1:0] rx_free, tx_free;
  assign rx_free = (rx_count_i >= RX_D) ? '0 : RX_D - rx_count_i;
  assign tx_free = (tx_count_i >= TX_D) ? '0 : TX_D - tx_count_i;

  always_comb begin
    unique case (mode_i)
      MODE_NORMAL: space_o = rx_free;
      MODE_ECHO:   space_o = (rx_free < tx_free) ? rx_free : tx_free;
      MODE_REMOTE: space_o = tx_free;
      default:     space_o = MX_D;
    endcase
  end

  assign ready_o = |space_o;
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
  import uart_router_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 64,
  parameter int unsigned TX_DEPTH = 64,
  parameter int unsigned DW       = 8,
  localparam int unsigned MAX_D   = (RX_DEPTH > TX_DEPTH) ? RX_DEPTH : TX_DEPTH,
  localparam int unsigned CW      = $clog2(MAX_D + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic              rx_valid_i,
  input  logic              rx_break_i,
  input  logic [DW-1:0]     rx_data_i,
  input  logic              cpu_wr_i,
  input  logic [DW-1:0]     cpu_wdata_i,
  input  logic              cpu_rd_i,
  output logic [DW-1:0]     cpu_rdata_o,
  input  logic              rxf_full_i,
  input  logic [CW-1:0]     rxf_count_i,
  input  logic [DW-1:0]     rxf_rdata_i,
  input  logic              txf_full_i,
  input  logic [CW-1:0]     txf_count_i,
  output logic              rxf_push_o,
  output logic [DW-1:0]     rxf_wdata_o,
  output logic              rxf_pop_o,
  output logic              rxf_flush_o,
  output logic              txf_push_o,
  output logic [DW-1:0]     txf_wdata_o,
  output logic              txf_flush_o,
  output logic              rx_ovr_o,
  output logic              tx_ovr_o,
  output logic [CW-1:0]     rx_space_o,
  output logic              rx_ready_o
);
  chan_mode_e    mode;
  logic          rx_en, tx_en;
  logic          rx_in;
  logic [DW-1:0] rx_byte;
  logic          rq_rx, rq_tx;
  logic [DW-1:0] d_rx, d_tx;

  assign mode    = chan_mode_e'(mode_i);
  assign rx_in   = rx_valid_i | rx_break_i;
  assign rx_byte = rx_break_i ? '0 : rx_data_i;

  uart_router_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .ctrl_o     (ctrl_o),
    .rx_en_o    (rx_en),
    .tx_en_o    (tx_en),
    .rx_flush_o (rxf_flush_o),
    .tx_flush_o (txf_flush_o)
  );

  // source selection per channel mode
  always_comb begin
    rq_rx = 1'b0;
    rq_tx = 1'b0;
    d_rx  = rx_byte;
    d_tx  = rx_byte;
    unique case (mode)
      MODE_NORMAL: begin
        rq_rx = rx_in;
        rq_tx = cpu_wr_i;
        d_tx  = cpu_wdata_i;
      end
      MODE_ECHO: begin
        rq_rx = rx_in;
        rq_tx = rx_in;
      end
      MODE_LOCAL: begin
        rq_rx = cpu_wr_i;
        d_rx  = cpu_wdata_i;
      end
      default: rq_tx = rx_in;
    endcase
  end

  uart_router_gate #(.DW(DW)) u_rx_gate (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .req_i (rq_rx), .data_i (d_rx), .en_i (rx_en), .full_i (rxf_full_i),
    .push_o (rxf_push_o), .wdata_o (rxf_wdata_o), .ovr_o (rx_ovr_o)
  );

  uart_router_gate #(.DW(DW)) u_tx_gate (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .req_i (rq_tx), .data_i (d_tx), .en_i (tx_en), .full_i (txf_full_i),
    .push_o (txf_push_o), .wdata_o (txf_wdata_o), .ovr_o (tx_ovr_o)
  );

  // processor read: head byte only when open and non-empty
  assign rxf_pop_o   = cpu_rd_i & rx_en & (rxf_count_i != '0);
  assign cpu_rdata_o = rxf_pop_o ? rxf_rdata_i : '0;

  uart_router_space #(.RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) u_space (
    .mode_i     (mode),
    .rx_count_i (rxf_count_i),
    .tx_count_i (txf_count_i),
    .space_o    (rx_space_o),
    .ready_o    (rx_ready_o)
  );

  // R2
  rx_push_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxf_push_o || rx_ovr_o) |-> ctrl_o[BIT_RX_EN] && !ctrl_o[BIT_RX_DIS]);
  // R2
  tx_push_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txf_push_o || tx_ovr_o) |-> ctrl_o[BIT_TX_EN] && !ctrl_o[BIT_TX_DIS]);
  // R3
  rst_bits_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[1:0] == 2'b00);
  // R6
  local_ignores_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) && rxf_push_o |-> cpu_wr_i && rxf_wdata_o == cpu_wdata_i);
  // R7
  remote_no_rx_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd3) |-> !rxf_push_o && !rx_ovr_o);
  // R10
  empty_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rd_i && rxf_count_i == '0 |-> cpu_rdata_o == '0 && !rxf_pop_o);
  // R11
  full_blocks_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxf_full_i && (mode_i == 2'd0 || mode_i == 2'd1) |-> !rx_ready_o);
endmodule

// File: tb/test_uart_chan_router.sv
`timescale 1ns/1ps
module test_uart_chan_router;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       ctrl_we = 1'b0;
  logic [8:0] ctrl_wdata = '0;
  logic [8:0] ctrl;
  logic       rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_data = '0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic       rxf_full = 1'b0, txf_full = 1'b0;
  logic [6:0] rxf_count = '0, txf_count = '0;
  logic [7:0] rxf_rdata = '0;
  logic       rxf_push, rxf_pop, rxf_flush, txf_push, txf_flush, rx_ovr, tx_ovr, rx_ready;
  logic [7:0] rxf_wdata, txf_wdata;
  logic [6:0] rx_space;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  uart_chan_router i_uart_chan_router (
    .clk_i (clk), .rst_ni (rst_n), .mode_i (mode),
    .ctrl_we_i (ctrl_we), .ctrl_wdata_i (ctrl_wdata), .ctrl_o (ctrl),
    .rx_valid_i (rx_valid), .rx_break_i (rx_break), .rx_data_i (rx_data),
    .cpu_wr_i (cpu_wr), .cpu_wdata_i (cpu_wdata), .cpu_rd_i (cpu_rd), .cpu_rdata_o (cpu_rdata),
    .rxf_full_i (rxf_full), .rxf_count_i (rxf_count), .rxf_rdata_i (rxf_rdata),
    .txf_full_i (txf_full), .txf_count_i (txf_count),
    .rxf_push_o (rxf_push), .rxf_wdata_o (rxf_wdata), .rxf_pop_o (rxf_pop), .rxf_flush_o (rxf_flush),
    .txf_push_o (txf_push), .txf_wdata_o (txf_wdata), .txf_flush_o (txf_flush),
    .rx_ovr_o (rx_ovr), .tx_ovr_o (tx_ovr), .rx_space_o (rx_space), .rx_ready_o (rx_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [8:0] v);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0; ctrl_wdata = '0;
    #1;
  endtask

  task automatic drive_rx(input logic [7:0] d, input bit brk);
    @(negedge clk);
    rx_valid = ~brk; rx_break = brk; rx_data = d;
    #1;
  endtask

  task automatic drive_cpu(input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_wdata = d;
    #1;
  endtask

  task automatic idle();
    rx_valid = 1'b0; rx_break = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R1 ctrl reset value", ctrl, 9'h128);
    mode = 2'd0;
    drive_rx(8'h11, 1'b0);
    chk("R1 rx push while disabled", rxf_push, 0);
    idle();
    drive_cpu(8'h22);
    chk("R1 tx push while disabled", txf_push, 0);
    idle();
  endtask

  task automatic t_enable();
    mode = 2'd0;
    wr_ctrl(9'h00C);
    drive_rx(8'h33, 1'b0);
    chk("R2 rx disable dominates", rxf_push, 0);
    idle();
    wr_ctrl(9'h034);
    drive_rx(8'h34, 1'b0);
    chk("R2 rx enabled push", rxf_push, 1);
    idle();
    drive_cpu(8'h35);
    chk("R2 tx disable dominates", txf_push, 0);
    idle();
    wr_ctrl(9'h014);
    drive_cpu(8'h36);
    chk("R2 tx enabled push", txf_push, 1);
    idle();
  endtask

  task automatic t_flush();
    wr_ctrl(9'h015);
    chk("R3 rx flush pulse", rxf_flush, 1);
    chk("R3 tx flush quiet", txf_flush, 0);
    chk("R3 reset bits read zero", ctrl, 9'h014);
    @(negedge clk); #1;
    chk("R3 rx flush one cycle", rxf_flush, 0);
    wr_ctrl(9'h016);
    chk("R3 tx flush pulse", txf_flush, 1);
    chk("R3 rx flush quiet", rxf_flush, 0);
    @(negedge clk); #1;
    chk("R3 tx flush one cycle", txf_flush, 0);
  endtask

  task automatic t_normal();
    mode = 2'd0;
    drive_rx(8'hA1, 1'b0);
    chk("R4 rx push", rxf_push, 1);
    chk("R4 rx data", rxf_wdata, 8'hA1);
    chk("R4 no tx push from rx", txf_push, 0);
    idle();
    drive_cpu(8'hB2);
    chk("R4 tx push", txf_push, 1);
    chk("R4 tx data", txf_wdata, 8'hB2);
    chk("R4 no rx push from cpu", rxf_push, 0);
    idle();
  endtask

  task automatic t_echo();
    mode = 2'd1;
    drive_rx(8'h5C, 1'b0);
    chk("R5 echo rx push", rxf_push, 1);
    chk("R5 echo tx push", txf_push, 1);
    chk("R5 echo tx data", txf_wdata, 8'h5C);
    idle();
    drive_cpu(8'h77);
    chk("R5 cpu ignored rx", rxf_push, 0);
    chk("R5 cpu ignored tx", txf_push, 0);
    idle();
  endtask

  task automatic t_local();
    mode = 2'd2;
    drive_cpu(8'h9D);
    chk("R6 loop push", rxf_push, 1);
    chk("R6 loop data", rxf_wdata, 8'h9D);
    chk("R6 no tx push", txf_push, 0);
    idle();
    drive_rx(8'h44, 1'b0);
    chk("R6 rx ignored rx", rxf_push, 0);
    chk("R6 rx ignored tx", txf_push, 0);
    idle();
  endtask

  task automatic t_remote();
    mode = 2'd3;
    drive_rx(8'hE7, 1'b0);
    chk("R7 tx push", txf_push, 1);
    chk("R7 tx data", txf_wdata, 8'hE7);
    chk("R7 no rx push", rxf_push, 0);
    idle();
    drive_cpu(8'h12);
    chk("R7 cpu ignored", {rxf_push, txf_push}, 2'b00);
    idle();
  endtask

  task automatic t_full();
    mode = 2'd1;
    rxf_full = 1'b1; rxf_count = 7'd64;
    drive_rx(8'h61, 1'b0);
    chk("R8 rx full no push", rxf_push, 0);
    chk("R8 rx overrun", rx_ovr, 1);
    chk("R8 tx still pushed", txf_push, 1);
    chk("R8 tx no overflow", tx_ovr, 0);
    idle();
    rxf_full = 1'b0; rxf_count = '0;
    mode = 2'd0;
    txf_full = 1'b1; txf_count = 7'd64;
    drive_cpu(8'h62);
    chk("R8 tx full no push", txf_push, 0);
    chk("R8 tx overflow", tx_ovr, 1);
    idle();
    txf_full = 1'b0; txf_count = '0;
    #1;
    chk("R8 overflow ends", {rx_ovr, tx_ovr}, 2'b00);
  endtask

  task automatic t_break();
    mode = 2'd0;
    drive_rx(8'hFF, 1'b1);
    chk("R9 break push", rxf_push, 1);
    chk("R9 break zero byte", rxf_wdata, 8'h00);
    idle();
    mode = 2'd3;
    drive_rx(8'hC3, 1'b1);
    chk("R9 break remote", {txf_push, txf_wdata}, 9'h100);
    idle();
  endtask

  task automatic t_read();
    mode = 2'd0;
    rxf_count = 7'd3; rxf_rdata = 8'hA5;
    @(negedge clk); cpu_rd = 1'b1; #1;
    chk("R10 pop", rxf_pop, 1);
    chk("R10 head data", cpu_rdata, 8'hA5);
    rxf_count = '0; #1;
    chk("R10 empty no pop", rxf_pop, 0);
    chk("R10 empty reads zero", cpu_rdata, 8'h00);
    idle();
    wr_ctrl(9'h01C);
    rxf_count = 7'd3;
    @(negedge clk); cpu_rd = 1'b1; #1;
    chk("R10 disabled no pop", rxf_pop, 0);
    chk("R10 disabled reads zero", cpu_rdata, 8'h00);
    idle();
    rxf_count = '0;
    wr_ctrl(9'h014);
  endtask

  task automatic t_space();
    mode = 2'd0; rxf_count = 7'd10; txf_count = 7'd60; #1;
    chk("R11 normal space", rx_space, 7'd54);
    mode = 2'd1; #1;
    chk("R11 echo min", rx_space, 7'd4);
    mode = 2'd3; rxf_count = 7'd0; #1;
    chk("R11 remote space", rx_space, 7'd4);
    mode = 2'd2; txf_count = 7'd64; rxf_count = 7'd64; #1;
    chk("R11 local max", rx_space, 7'd64);
    chk("R11 local ready", rx_ready, 1);
    mode = 2'd0; rxf_full = 1'b1; #1;
    chk("R11 full space", rx_space, 7'd0);
    chk("R11 full not ready", rx_ready, 0);
    rxf_full = 1'b0; rxf_count = '0; txf_count = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_flush();
    t_normal();
    t_echo();
    t_local();
    t_remote();
    t_full();
    t_break();
    t_read();
    t_space();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule